// File: doc/BRIEF.md
# Edge-Triggered Pin Interrupt Unit

This block watches a bank of already-synchronised input pins and turns selected transitions into a single level interrupt request. Every pin has a two-bit edge selector, so it can catch a low-to-high change, a high-to-low change, both, or neither. A caught edge sets the pin's pending flag. A per-pin block bit decides whether that flag reaches the shared request line. The request stays high as long as any unblocked flag is pending. Software clears flags by writing ones to them. A control bit can also make a read of a flag byte clear the flags it returned.

All state is reached through a byte-wide register port that has a one-cycle read latency. A second control bit changes how blocked pins behave. When it is set, edges on blocked pins are dropped instead of being recorded silently. A third control bit is kept as a plain stored flag that software can read back.

Top module: `gpio_eirq_top`

## Requirements
- R1: After a synchronous reset, all pending flags, edge selectors and control bits are 0, every block bit is 1, and the request output is low.
- R2: The edge selectors fill the bytes at addresses 6 to 10, four pins per byte, with pin n in byte 6 + n/4. For k = n mod 4, bit 2k enables high-to-low detection and bit 2k+1 enables low-to-high detection. Setting both makes either transition count.
- R3: Pending flags are at addresses 0 to 2 and block bits at addresses 3 to 5, little-endian: pin n is bit n mod 8 of byte n/8 within each group.
- R4: A write to a pending byte clears each flag whose data bit is 1 and leaves a flag unchanged where the data bit is 0.
- R5: The request output is high exactly when some pin has its pending flag at 1 and its block bit at 0, and it holds at that level until the flag is cleared or the pin is blocked.
- R6: With control bit 2 set, a read of a pending byte returns the flags and clears exactly those flags at the same clock edge. An edge recorded in the same cycle as that read stays pending.
- R7: With control bit 1 set, edges on blocked pins are not recorded. With it clear, they are recorded but do not raise the request.
- R8: If an enabled edge and a clearing access hit the same flag in the same cycle, the flag ends up set.
- R9: The control register at address 11 stores bits 2:0 (bit 0 a stored exclusive-access flag, bit 1 pending-disable, bit 2 clear-on-read). On read, bits 7:3 return 0.
- R10: Read data appears on the cycle after the read strobe and is 0 on any cycle that does not follow a read. Reads of addresses 12 and above return 0.
- R11: Register bits that map to no pin (pending and block bits 18 to 23, edge byte 10 bits 7:4) ignore writes and read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pins_i | input | 18 | Synchronised pin levels |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 4 | Register byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, one cycle after the strobe |
| irq_o | output | 1 | Combined level interrupt request |

## Verification
The bench uses the default configuration: 18 pins and a 4-bit address. With this configuration the top pending and block bytes are only partly populated, the last edge byte is half used, and addresses 12 to 15 are unmapped. Padding and out-of-range reads therefore come up in both the directed and the random traffic. The small pin count also lets random toggling pile up several pending pins at once. Clear-on-read, pending-disable and edge-versus-clear collisions can then occur on the same byte, and the behavioural model compares every cycle of that traffic.

// File: rtl/gpio_eirq_pkg.sv
package gpio_eirq_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        KIND_NONE = 3'd0,
        KIND_STAT = 3'd1,
        KIND_MASK = 3'd2,
        KIND_EDGE = 3'd3,
        KIND_CTRL = 3'd4
    } reg_kind_t;

    // bit 0 excl_en, bit 1 pend_dis, bit 2 clr_on_rd
    typedef struct packed {
        logic clr_on_rd;
        logic pend_dis;
        logic excl_en;
    } irq_ctrl_t;

    typedef struct packed {
        reg_kind_t kind;
        logic [7:0] offset;
    } reg_sel_t;

    function automatic int stat_bytes(int pins);
        return (pins + 7) / 8;
    endfunction

    function automatic int edge_bytes(int pins);
        return (pins + 3) / 4;
    endfunction

    function automatic reg_sel_t classify(int a, int pins);
        reg_sel_t s;
        int sb;
        int eb;
        sb = stat_bytes(pins);
        eb = edge_bytes(pins);
        s.kind = KIND_NONE;
        s.offset = '0;
        if (a < sb) begin
            s.kind = KIND_STAT;
            s.offset = 8'(a);
        end else if (a < 2 * sb) begin
            s.kind = KIND_MASK;
            s.offset = 8'(a - sb);
        end else if (a < 2 * sb + eb) begin
            s.kind = KIND_EDGE;
            s.offset = 8'(a - 2 * sb);
        end else if (a == 2 * sb + eb) begin
            s.kind = KIND_CTRL;
        end
        return s;
    endfunction

endpackage

// File: rtl/gpio_eirq_edge.sv
module gpio_eirq_edge #(
    parameter int unsigned NUM_PINS = 18
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [NUM_PINS-1:0] pins_i,
    output logic [NUM_PINS-1:0] rise_o,
    output logic [NUM_PINS-1:0] fall_o
);

    logic [NUM_PINS-1:0] prev_q;

    // During reset the history follows the pins, so release brings no edge
    always_ff @(posedge clk_i) begin
        prev_q <= pins_i;
    end

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        assign rise_o[n] = pins_i[n] & ~prev_q[n];
        assign fall_o[n] = ~pins_i[n] & prev_q[n];
    end

    // Interface check only: reset is unused here on purpose
    logic unused_rst;
    assign unused_rst = rst_i;

endmodule

// File: rtl/gpio_eirq_status.sv
module gpio_eirq_status #(
    parameter int unsigned NUM_PINS = 18
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [NUM_PINS-1:0] rise_i,
    input  logic [NUM_PINS-1:0] fall_i,
    input  logic [NUM_PINS-1:0] rise_en_i,
    input  logic [NUM_PINS-1:0] fall_en_i,
    input  logic [NUM_PINS-1:0] mask_i,
    input  logic                pend_dis_i,
    input  logic [NUM_PINS-1:0] clr_i,
    output logic [NUM_PINS-1:0] status_o
);

    logic [NUM_PINS-1:0] status_q;
    logic [NUM_PINS-1:0] hit;
    logic [NUM_PINS-1:0] drop;
    logic [NUM_PINS-1:0] record;
    logic [NUM_PINS-1:0] status_d;

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_bit
        assign hit[n]      = (rise_i[n] & rise_en_i[n]) | (fall_i[n] & fall_en_i[n]);
        assign drop[n]     = pend_dis_i & mask_i[n];
        assign record[n]   = hit[n] & ~drop[n];
        // a fresh edge beats a clear in the same cycle
        assign status_d[n] = record[n] | (status_q[n] & ~clr_i[n]);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            status_q <= '0;
        end else begin
            status_q <= status_d;
        end
    end

    assign status_o = status_q;

    assert_w1c_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> ((status_q & $past(clr_i & ~((rise_i & rise_en_i) | (fall_i & fall_en_i)))) == '0));

    assert_hold_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (clr_i == '0 && ((rise_i & rise_en_i) | (fall_i & fall_en_i)) == '0) |=> $stable(status_q));

    assert_edge_wins_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> ((status_q & $past(rise_i & rise_en_i & ~mask_i)) == $past(rise_i & rise_en_i & ~mask_i)));

    assert_pend_dis_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        pend_dis_i |=> ((status_q & ~$past(status_q) & $past(mask_i)) == '0));

endmodule

// File: rtl/gpio_eirq_regs.sv
module gpio_eirq_regs
    import gpio_eirq_pkg::*;
#(
    parameter int unsigned NUM_PINS = 18,
    parameter int unsigned ADDR_W   = 4
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                wr_i,
    input  logic                rd_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [7:0]          wdata_i,
    input  logic [NUM_PINS-1:0] status_i,
    output logic [7:0]          rdata_o,
    output logic [NUM_PINS-1:0] mask_o,
    output logic [NUM_PINS-1:0] rise_en_o,
    output logic [NUM_PINS-1:0] fall_en_o,
    output logic [NUM_PINS-1:0] clr_o,
    output irq_ctrl_t           ctrl_o
);

    localparam int SB       = stat_bytes(NUM_PINS);
    localparam int EB       = edge_bytes(NUM_PINS);
    localparam int STAT_PAD = SB * 8;
    localparam int EDGE_PAD = EB * 8;
    localparam int LAST_A   = 2 * SB + EB;

    logic [NUM_PINS-1:0] mask_q, mask_d;
    logic [NUM_PINS-1:0] rise_q, rise_d;
    logic [NUM_PINS-1:0] fall_q, fall_d;
    irq_ctrl_t           ctrl_q, ctrl_d;
    logic [7:0]          rdata_q, rd_mux;
    logic [STAT_PAD-1:0] stat_pad, mask_pad;
    logic [EDGE_PAD-1:0] edge_pad;
    reg_sel_t            sel;
    int                  addr_int;

    assign addr_int = int'(addr_i);
    assign sel      = classify(addr_int, NUM_PINS);

    // per-pin write decode, including the clear strobes for the flags
    for (genvar n = 0; n < NUM_PINS; n++) begin : g_clr
        localparam int BYTE_IX = n / 8;
        localparam int BIT_IX  = n % 8;
        assign clr_o[n] = (sel.kind == KIND_STAT) && (int'(sel.offset) == BYTE_IX) &&
                          ((wr_i && wdata_i[BIT_IX]) || (rd_i && ctrl_q.clr_on_rd));
    end

    always_comb begin
        mask_d = mask_q;
        rise_d = rise_q;
        fall_d = fall_q;
        ctrl_d = ctrl_q;
        if (wr_i) begin
            for (int n = 0; n < NUM_PINS; n++) begin
                if (sel.kind == KIND_MASK && int'(sel.offset) == n / 8) begin
                    mask_d[n] = wdata_i[n % 8];
                end
                if (sel.kind == KIND_EDGE && int'(sel.offset) == n / 4) begin
                    fall_d[n] = wdata_i[2 * (n % 4)];
                    rise_d[n] = wdata_i[2 * (n % 4) + 1];
                end
            end
            if (sel.kind == KIND_CTRL) begin
                ctrl_d = irq_ctrl_t'(wdata_i[2:0]);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            mask_q <= '1;
            rise_q <= '0;
            fall_q <= '0;
            ctrl_q <= '0;
        end else begin
            mask_q <= mask_d;
            rise_q <= rise_d;
            fall_q <= fall_d;
            ctrl_q <= ctrl_d;
        end
    end

    // read views with unused positions tied to zero
    always_comb begin
        stat_pad = '0;
        mask_pad = '0;
        edge_pad = '0;
        stat_pad[NUM_PINS-1:0] = status_i;
        mask_pad[NUM_PINS-1:0] = mask_q;
        for (int n = 0; n < NUM_PINS; n++) begin
            edge_pad[2 * n]     = fall_q[n];
            edge_pad[2 * n + 1] = rise_q[n];
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (sel.kind)
            KIND_STAT: rd_mux = stat_pad[int'(sel.offset) * 8 +: 8];
            KIND_MASK: rd_mux = mask_pad[int'(sel.offset) * 8 +: 8];
            KIND_EDGE: rd_mux = edge_pad[int'(sel.offset) * 8 +: 8];
            KIND_CTRL: rd_mux = {5'b0, ctrl_q};
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rd_i ? rd_mux : '0;
        end
    end

    assign rdata_o   = rdata_q;
    assign mask_o    = mask_q;
    assign rise_en_o = rise_q;
    assign fall_en_o = fall_q;
    assign ctrl_o    = ctrl_q;

    assert_mask_reset_R1: assert property (@(posedge clk_i)
        rst_i |=> (mask_q == '1 && rise_q == '0 && fall_q == '0));

    assert_unmapped_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_i && addr_int > LAST_A) |=> (rdata_o == 8'h00));

    assert_idle_rdata_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        !rd_i |=> (rdata_o == 8'h00));

    assert_ctrl_upper_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_i && addr_int == LAST_A) |=> (rdata_o[7:3] == 5'b0));

endmodule

// File: rtl/gpio_eirq_top.sv
module gpio_eirq_top
    import gpio_eirq_pkg::*;
#(
    parameter int unsigned NUM_PINS = 18,
    parameter int unsigned ADDR_W   = 4
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [NUM_PINS-1:0] pins_i,
    input  logic                wr_en_i,
    input  logic                rd_en_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [7:0]          wdata_i,
    output logic [7:0]          rdata_o,
    output logic                irq_o
);

    logic [NUM_PINS-1:0] rise, fall;
    logic [NUM_PINS-1:0] rise_en, fall_en;
    logic [NUM_PINS-1:0] mask, clr, status;
    irq_ctrl_t           ctrl;

    gpio_eirq_edge #(.NUM_PINS(NUM_PINS)) u_edge (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .pins_i (pins_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    gpio_eirq_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_i      (wr_en_i),
        .rd_i      (rd_en_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .status_i  (status),
        .rdata_o   (rdata_o),
        .mask_o    (mask),
        .rise_en_o (rise_en),
        .fall_en_o (fall_en),
        .clr_o     (clr),
        .ctrl_o    (ctrl)
    );

    gpio_eirq_status #(.NUM_PINS(NUM_PINS)) u_status (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .rise_i     (rise),
        .fall_i     (fall),
        .rise_en_i  (rise_en),
        .fall_en_i  (fall_en),
        .mask_i     (mask),
        .pend_dis_i (ctrl.pend_dis),
        .clr_i      (clr),
        .status_o   (status)
    );

    assign irq_o = |(status & ~mask);

    assert_all_blocked_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (mask == '1) |-> !irq_o);

    assert_level_hold_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (irq_o && clr == '0 && !wr_en_i) |=> irq_o);

endmodule

// File: tb/tb_gpio_eirq_top.sv
`timescale 1ns/1ps
module tb_gpio_eirq_top;

    localparam int NP = 18;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [NP-1:0] pins = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata_o;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference state
    bit [NP-1:0] m_stat, m_mask, m_rise, m_fall, m_prev;
    bit [2:0]    m_ctrl;
    bit [7:0]    m_rd_exp;

    always #2 clk = ~clk;

    gpio_eirq_top dut (
        .clk_i   (clk),
        .rst_i   (rst),
        .pins_i  (pins),
        .wr_en_i (wr),
        .rd_en_i (rd),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata_o),
        .irq_o   (irq_o)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit [7:0] model_read(int a);
        bit [23:0] s;
        bit [23:0] k;
        bit [39:0] e;
        s = 24'(m_stat);
        k = 24'(m_mask);
        e = '0;
        for (int n = 0; n < NP; n++) begin
            e[2 * n]     = m_fall[n];
            e[2 * n + 1] = m_rise[n];
        end
        if (a <= 2) return s[a * 8 +: 8];
        if (a <= 5) return k[(a - 3) * 8 +: 8];
        if (a <= 10) return e[(a - 6) * 8 +: 8];
        if (a == 11) return {5'b0, m_ctrl};
        return 8'h00;
    endfunction

    task automatic model_step();
        bit [NP-1:0] nxt;
        int a;
        a = int'(addr);
        if (rst) begin
            m_stat = '0; m_mask = '1; m_rise = '0; m_fall = '0;
            m_ctrl = '0; m_prev = pins; m_rd_exp = '0;
            return;
        end
        m_rd_exp = rd ? model_read(a) : 8'h00;
        nxt = m_stat;
        for (int n = 0; n < NP; n++) begin
            bit up, dn, hit, clr;
            up  = pins[n] && !m_prev[n];
            dn  = !pins[n] && m_prev[n];
            hit = (up && m_rise[n]) || (dn && m_fall[n]);
            if (m_ctrl[1] && m_mask[n]) hit = 1'b0;
            clr = (a == n / 8) && ((wr && wdata[n % 8]) || (rd && m_ctrl[2]));
            if (hit) nxt[n] = 1'b1;
            else if (clr) nxt[n] = 1'b0;
        end
        m_stat = nxt;
        if (wr) begin
            for (int n = 0; n < NP; n++) begin
                if (a == 3 + n / 8) m_mask[n] = wdata[n % 8];
                if (a == 6 + n / 4) begin
                    m_fall[n] = wdata[2 * (n % 4)];
                    m_rise[n] = wdata[2 * (n % 4) + 1];
                end
            end
            if (a == 11) m_ctrl = wdata[2:0];
        end
        m_prev = pins;
    endtask

    // one clock: inputs set before, model on the edge, compare at negedge
    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check("R5 irq level", irq_o, |(m_stat & ~m_mask));
        check("R10 rdata", rdata_o, m_rd_exp);
    endtask

    task automatic bus_write(int a, int d);
        wr = 1'b1; addr = 4'(a); wdata = 8'(d);
        cycle();
        wr = 1'b0;
    endtask

    task automatic read_expect(int a, int exp, string tag);
        rd = 1'b1; addr = 4'(a);
        cycle();
        rd = 1'b0;
        check(tag, rdata_o, exp);
    endtask

    task automatic set_pins(logic [NP-1:0] v);
        pins = v;
        cycle();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        pins = 18'h2AAAA;
        rst = 1'b1;
        repeat (3) cycle();
        rst = 1'b0;
        cycle();
        // R1 reset contents
        for (int a = 0; a < 3; a++) read_expect(a, 8'h00, "R1 pending reset");
        read_expect(3, 8'hFF, "R1 block reset");
        read_expect(4, 8'hFF, "R1 block reset");
        read_expect(5, 8'h03, "R1 block reset");
        for (int a = 6; a < 11; a++) read_expect(a, 8'h00, "R1 edge reset");
        read_expect(11, 8'h00, "R1 control reset");
        check("R1 irq low", irq_o, 1'b0);
        // R10 unmapped and idle data
        read_expect(12, 8'h00, "R10 unmapped");
        read_expect(15, 8'h00, "R10 unmapped");
        cycle();
        check("R10 idle rdata", rdata_o, 8'h00);

        // R2 edge fields: pin0 rise, pin1 fall, pin2 both, pin3 none
        set_pins('0);
        bus_write(6, 8'h36);
        read_expect(6, 8'h36, "R2 edge readback");
        set_pins(18'h0000F);
        read_expect(0, 8'h05, "R2 rising edges");
        bus_write(0, 8'hFF);
        read_expect(0, 8'h00, "R4 clear all");
        set_pins('0);
        read_expect(0, 8'h06, "R2 falling edges");
        check("R5 blocked no irq", irq_o, 1'b0);
        bus_write(3, 8'hFD);
        cycle();
        check("R5 unblocked irq", irq_o, 1'b1);
        bus_write(0, 8'h00);
        read_expect(0, 8'h06, "R4 zero write no effect");
        bus_write(0, 8'h02);
        read_expect(0, 8'h04, "R4 single clear");
        check("R5 irq drops", irq_o, 1'b0);

        // R3 top pin lands in byte 2 bit 1
        bus_write(10, 8'h0C);
        set_pins(18'h20000);
        read_expect(2, 8'h02, "R3 pin17 position");
        read_expect(0, 8'h04, "R3 byte0 untouched");
        bus_write(5, 8'h01);
        read_expect(5, 8'h01, "R3 block byte2");
        check("R5 pin17 irq", irq_o, 1'b1);
        bus_write(2, 8'h02);
        check("R4 pin17 cleared", irq_o, 1'b0);

        // R8 edge and clear in the same cycle
        set_pins('0);
        pins = 18'h20000; wr = 1'b1; addr = 4'd2; wdata = 8'h02;
        cycle();
        wr = 1'b0;
        read_expect(2, 8'h02, "R8 edge wins");

        // R6 clear on read
        bus_write(11, 8'h04);
        read_expect(2, 8'h02, "R6 first read");
        read_expect(2, 8'h00, "R6 cleared by read");
        set_pins('0);
        pins = 18'h20000; rd = 1'b1; addr = 4'd2;
        cycle();
        rd = 1'b0;
        check("R6 read with edge", rdata_o, 8'h02);
        read_expect(2, 8'h02, "R6 edge kept");
        read_expect(2, 8'h00, "R6 cleared after");
        read_expect(0, 8'h04, "R6 other byte kept");
        read_expect(0, 8'h00, "R6 byte0 cleared");

        // R7 pending disable
        bus_write(11, 8'h02);
        bus_write(3, 8'hFF);
        set_pins(18'h20004);
        read_expect(0, 8'h00, "R7 dropped when blocked");
        bus_write(11, 8'h00);
        set_pins(18'h20000);
        read_expect(0, 8'h04, "R7 recorded when off");
        check("R7 recorded but quiet", irq_o, 1'b0);
        bus_write(3, 8'hFB);
        check("R5 late unblock", irq_o, 1'b1);
        bus_write(0, 8'h04);
        check("R4 clear drops irq", irq_o, 1'b0);

        // R9 control register width
        bus_write(11, 8'hFF);
        read_expect(11, 8'h07, "R9 control bits");
        bus_write(11, 8'h00);
        read_expect(11, 8'h00, "R9 control cleared");

        // R11 padding bits
        bus_write(5, 8'hFF);
        read_expect(5, 8'h03, "R11 block padding");
        bus_write(10, 8'hFF);
        read_expect(10, 8'h0F, "R11 edge padding");
        bus_write(2, 8'hFF);
        read_expect(2, 8'h00, "R11 pending padding");

        // random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            int op;
            op = int'($urandom % 10);
            pins = pins ^ NP'($urandom & $urandom & $urandom);
            wr = 1'b0; rd = 1'b0;
            addr = 4'($urandom % 14);
            wdata = 8'($urandom);
            if (op < 2) wr = 1'b1;
            else if (op < 5) rd = 1'b1;
            cycle();
        end
        wr = 1'b0; rd = 1'b0;
        cycle();
        finish_run();
    end

endmodule